// File: doc/BRIEF.md
# Serial Clock Rate Selector

This block picks the bit-clock source for every receiver and every transmitter in a multi-channel serial controller. Each source has its own 4-bit selection code. Codes 0 to 12 choose a fixed rate from a table. The chip-wide rate-set bit chooses between two variants of that table. Each fixed rate becomes a divisor of the reference clock and drives a down-counter that gives a one-cycle 16x clock-enable pulse. The three top codes do not use the table. They route either a counter/timer tick or an external per-source enable pulse to the output. The external pulse can be taken as a 16x clock or as a 1x clock.

Two hidden chip-wide modes act on every source at once. A rate test flag toggles on every bus read of address 2. While it is set, the table is replaced by an alternate set of extended rates. A separate force flag is written through address A. While it is set, every receiver and transmitter is marked as running in 1x mode. Sources are numbered so that even indices are receivers and odd indices are transmitters.

Top module: `brs_clock_select`

## Requirements
- R1: After reset, test_mode is 0, force_1x is 0 and every src_ce bit is 0.
- R2: A cycle with bus_rd high and bus_addr equal to 2 inverts test_mode from the next cycle onward. A read at any other address, or a write to address 2, leaves test_mode unchanged.
- R3: A cycle with bus_wr high and bus_addr equal to 10 loads bus_wbit into force_1x from the next cycle. A read at address 10 leaves force_1x unchanged.
- R4: With test_mode 0 and rate_set 0, codes 0 to 12 select 50, 110, 134.5, 200, 300, 600, 1200, 1050, 2400, 4800, 7200, 9600 and 38400 baud. src_div equals round(REF_HZ / (16 x rate)); at the default 3686400 Hz this gives 4608 for code 0 and 24 for code 11.
- R5: With test_mode 0 and rate_set 1, codes 0, 3, 7, 10 and 12 select 75, 150, 2000, 1800 and 19200 baud. The other codes are the same as under R4.
- R6: With test_mode 1, codes 0 to 12 select 4800, 880, 1076, 19200, 28800, 57600, 115200, 1050, 57600, 4800, 57600, 9600 and 38400 baud when rate_set is 0. When rate_set is 1, codes 0, 3, 7, 10 and 12 become 7200, 14400, 2000, 14400 and 19200 baud.
- R7: One toggle of test_mode changes the divisor of every source in the same cycle.
- R8: For codes 0 to 12, src_ce is a one-cycle pulse that repeats every src_div clock cycles. src_1x stays 0 unless force_1x is set.
- R9: Code 13 makes src_ce equal timer_ce delayed by one cycle. src_div reads 0 for this code.
- R10: Code 14 makes src_ce equal that source's ext_ce delayed by one cycle, with src_1x 0. Code 15 does the same with src_1x 1.
- R11: While force_1x is 1, every src_1x bit is 1 whatever the codes are.
- R12: When a source's divisor changes in the middle of a count, the interval already running ends at the old length. The interval after it uses the new divisor, so no short pulse gap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the divisors count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_addr | input | 4 | Register address of the current access |
| bus_wbit | input | 1 | Write data bit that goes to the force-1x flag |
| rate_set | input | 1 | Chip-wide choice between the two table variants |
| sel_code | input | 2*NCH x 4 | Selection code per source (even = receiver, odd = transmitter) |
| timer_ce | input | 1 | Counter/timer tick, used by code 13 |
| ext_ce | input | 2*NCH | External enable pulse per source, used by codes 14 and 15 |
| test_mode | output | 1 | Rate test flag |
| force_1x | output | 1 | Force-1x flag |
| src_ce | output | 2*NCH | Registered clock-enable pulse per source |
| src_1x | output | 2*NCH | 1 when that source's enable is a 1x clock |
| src_div | output | 2*NCH x 16 | Divisor currently selected per source; 0 for codes 13 to 15 |

## Verification
test_mode and force_1x change one cycle after the qualifying strobe. src_div follows the codes and flags with no register in between, so the bench reads both flags and the divisors at the falling edge after the access. The bypass codes put out a pulse one cycle after timer_ce or ext_ce. The bench raises that input for one cycle and then expects src_ce high at the next falling edge and low at the one after. Divider periods are measured between successive src_ce pulses once two pulses have been thrown away to drop any partial interval. For R12, the code changes right after a pulse, so one old-length interval is expected first and then the new one.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [1:0] {
    SRC_DIV   = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_EXT16 = 2'd2,
    SRC_EXT1  = 2'd3
  } src_kind_e;

  localparam logic [3:0] CODE_TIMER = 4'd13;
  localparam logic [3:0] CODE_EXT16 = 4'd14;
  localparam logic [3:0] CODE_EXT1  = 4'd15;

  function automatic src_kind_e kind_of(input logic [3:0] code);
    case (code)
      CODE_TIMER: return SRC_TIMER;
      CODE_EXT16: return SRC_EXT16;
      CODE_EXT1:  return SRC_EXT1;
      default:    return SRC_DIV;
    endcase
  endfunction

  // pick one of four candidates by {test, alt}
  function automatic int unsigned pick4(input logic test, input logic alt,
                                        input int unsigned n0, input int unsigned n1,
                                        input int unsigned t0, input int unsigned t1);
    case ({test, alt})
      2'b00:   return n0;
      2'b01:   return n1;
      2'b10:   return t0;
      default: return t1;
    endcase
  endfunction

  // rate in tenths of a baud; 0 for codes that bypass the divider
  function automatic int unsigned rate_tenths(input logic test, input logic alt,
                                              input logic [3:0] code);
    case (code)
      4'd0:    return pick4(test, alt,    500,    750,   48000,   72000);
      4'd1:    return pick4(test, alt,   1100,   1100,    8800,    8800);
      4'd2:    return pick4(test, alt,   1345,   1345,   10760,   10760);
      4'd3:    return pick4(test, alt,   2000,   1500,  192000,  144000);
      4'd4:    return pick4(test, alt,   3000,   3000,  288000,  288000);
      4'd5:    return pick4(test, alt,   6000,   6000,  576000,  576000);
      4'd6:    return pick4(test, alt,  12000,  12000, 1152000, 1152000);
      4'd7:    return pick4(test, alt,  10500,  20000,   10500,   20000);
      4'd8:    return pick4(test, alt,  24000,  24000,  576000,  576000);
      4'd9:    return pick4(test, alt,  48000,  48000,   48000,   48000);
      4'd10:   return pick4(test, alt,  72000,  18000,  576000,  144000);
      4'd11:   return pick4(test, alt,  96000,  96000,   96000,   96000);
      4'd12:   return pick4(test, alt, 384000, 192000,  384000,  192000);
      default: return 0;
    endcase
  endfunction

  // rounded count of reference cycles per 16x tick
  function automatic int unsigned divisor_of(input int unsigned ref_hz,
                                             input int unsigned r10);
    int unsigned num;
    if (r10 == 0) return 0;
    num = (ref_hz * 10) / 16;
    return (num + r10 / 2) / r10;
  endfunction

endpackage

// File: rtl/brs_mode_regs.sv
module brs_mode_regs #(
  parameter int          AW       = 4,
  parameter logic [AW-1:0] TOG_ADDR = 4'h2,
  parameter logic [AW-1:0] F1X_ADDR = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wbit,
  output logic          test_mode,
  output logic          force_1x,
  output logic          tog_hit,
  output logic          f1x_hit
);

  assign tog_hit = bus_rd && (bus_addr == TOG_ADDR);
  assign f1x_hit = bus_wr && (bus_addr == F1X_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      test_mode <= 1'b0;
      force_1x  <= 1'b0;
    end else begin
      if (tog_hit) test_mode <= ~test_mode;
      if (f1x_hit) force_1x  <= bus_wbit;
    end
  end

endmodule

// File: rtl/brs_rate_lut.sv
module brs_rate_lut
  import brs_pkg::*;
#(
  parameter int unsigned REF_HZ = 3686400,
  parameter int          DW     = 16
) (
  input  logic [3:0]    code,
  input  logic          alt,
  input  logic          test,
  output src_kind_e     kind,
  output logic [DW-1:0] divisor
);

  assign kind    = kind_of(code);
  assign divisor = DW'(divisor_of(REF_HZ, rate_tenths(test, alt, code)));

endmodule

// File: rtl/brs_divider.sv
module brs_divider
  import brs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_kind_e     kind,
  input  logic [DW-1:0] divisor,
  input  logic          timer_ce,
  input  logic          ext_ce,
  input  logic          force_1x,
  output logic          ce_out,
  output logic          is_1x,
  output logic          div_tick
);

  logic [DW-1:0] cnt_q;
  logic          sel_pulse;

  assign div_tick = (kind == SRC_DIV) && (cnt_q == '0);

  always_comb begin
    case (kind)
      SRC_DIV:   sel_pulse = div_tick;
      SRC_TIMER: sel_pulse = timer_ce;
      default:   sel_pulse = ext_ce;
    endcase
  end

  assign is_1x = force_1x || (kind == SRC_EXT1);

  // divisor sampled only at reload: a change waits for the running count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ce_out <= 1'b0;
    end else begin
      if (kind != SRC_DIV)     cnt_q <= '0;
      else if (cnt_q == '0)    cnt_q <= divisor - DW'(1);
      else                     cnt_q <= cnt_q - DW'(1);
      ce_out <= sel_pulse;
    end
  end

endmodule

// File: rtl/brs_clock_select.sv
module brs_clock_select
  import brs_pkg::*;
#(
  parameter int          NCH    = 2,
  parameter int unsigned REF_HZ = 3686400,
  parameter int          DW     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  input  logic [3:0]                  bus_addr,
  input  logic                        bus_wbit,
  input  logic                        rate_set,
  input  logic [2*NCH-1:0][3:0]       sel_code,
  input  logic                        timer_ce,
  input  logic [2*NCH-1:0]            ext_ce,
  output logic                        test_mode,
  output logic                        force_1x,
  output logic [2*NCH-1:0]            src_ce,
  output logic [2*NCH-1:0]            src_1x,
  output logic [2*NCH-1:0][DW-1:0]    src_div
);

  localparam int NSRC = 2 * NCH;

  logic            tog_hit;
  logic            f1x_hit;
  logic [NSRC-1:0] div_tick;

  brs_mode_regs #(.AW(4), .TOG_ADDR(4'h2), .F1X_ADDR(4'hA)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wbit  (bus_wbit),
    .test_mode (test_mode),
    .force_1x  (force_1x),
    .tog_hit   (tog_hit),
    .f1x_hit   (f1x_hit)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    src_kind_e     kind;
    logic [DW-1:0] divisor;

    brs_rate_lut #(.REF_HZ(REF_HZ), .DW(DW)) u_lut (
      .code    (sel_code[i]),
      .alt     (rate_set),
      .test    (test_mode),
      .kind    (kind),
      .divisor (divisor)
    );

    brs_divider #(.DW(DW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .divisor  (divisor),
      .timer_ce (timer_ce),
      .ext_ce   (ext_ce[i]),
      .force_1x (force_1x),
      .ce_out   (src_ce[i]),
      .is_1x    (src_1x[i]),
      .div_tick (div_tick[i])
    );

    assign src_div[i] = divisor;
  end

endmodule

// File: rtl/brs_clock_select_chk.sv
module brs_clock_select_chk #(
  parameter int NCH = 2,
  parameter int DW  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wbit,
  input logic [2*NCH-1:0][3:0]    sel_code,
  input logic                     timer_ce,
  input logic [2*NCH-1:0]         ext_ce,
  input logic                     test_mode,
  input logic                     force_1x,
  input logic [2*NCH-1:0]         src_ce,
  input logic [2*NCH-1:0]         src_1x,
  input logic                     tog_hit,
  input logic                     f1x_hit
);

  // R2
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog_hit |=> test_mode != $past(test_mode));

  // R2
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_hit |=> $stable(test_mode));

  // R3
  f1x_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f1x_hit |=> force_1x == $past(bus_wbit));

  // R11
  f1x_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_1x |-> (&src_1x));

  for (genvar i = 0; i < 2*NCH; i++) begin : g_chk
    // R9
    timer_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_code[i] == 4'd13 |=> src_ce[i] == $past(timer_ce));

    // R10
    ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_code[i] >= 4'd14 |=> src_ce[i] == $past(ext_ce[i]));

    // R10
    ext1_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_code[i] == 4'd15 |-> src_1x[i]);

    // R8
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ce[i] && sel_code[i] <= 4'd12 && $past(sel_code[i]) <= 4'd12) |=> !src_ce[i]);
  end

endmodule

bind brs_clock_select brs_clock_select_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wbit  (bus_wbit),
  .sel_code  (sel_code),
  .timer_ce  (timer_ce),
  .ext_ce    (ext_ce),
  .test_mode (test_mode),
  .force_1x  (force_1x),
  .src_ce    (src_ce),
  .src_1x    (src_1x),
  .tog_hit   (tog_hit),
  .f1x_hit   (f1x_hit)
);

// File: tb/brs_clock_select_bench.sv
module brs_clock_select_bench;

  localparam int NCH  = 2;
  localparam int NSRC = 2 * NCH;
  localparam int DW   = 16;
  localparam real REFR = 3686400.0;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  bus_rd = 1'b0, bus_wr = 1'b0, bus_wbit = 1'b0;
  logic [3:0]            bus_addr = 4'h0;
  logic                  rate_set = 1'b0;
  logic [NSRC-1:0][3:0]  sel_code;
  logic                  timer_ce = 1'b0;
  logic [NSRC-1:0]       ext_ce = '0;
  logic                  test_mode, force_1x;
  logic [NSRC-1:0]       src_ce, src_1x;
  logic [NSRC-1:0][DW-1:0] src_div;

  int total = 0, bad = 0, cyc = 0;
  int pulse_cnt = 0, last_pulse = 0;
  bit have_last = 0, done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brs_clock_select #(.NCH(NCH), .REF_HZ(3686400), .DW(DW)) u_brs_clock_select (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wbit(bus_wbit), .rate_set(rate_set), .sel_code(sel_code), .timer_ce(timer_ce),
    .ext_ce(ext_ce), .test_mode(test_mode), .force_1x(force_1x), .src_ce(src_ce),
    .src_1x(src_1x), .src_div(src_div)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // baud per code, from the requirement lists
  function automatic real baud(bit tst, bit alt, int code);
    real n[13]  = '{50.0, 110.0, 134.5, 200.0, 300.0, 600.0, 1200.0, 1050.0, 2400.0, 4800.0, 7200.0, 9600.0, 38400.0};
    real t[13]  = '{4800.0, 880.0, 1076.0, 19200.0, 28800.0, 57600.0, 115200.0, 1050.0, 57600.0, 4800.0, 57600.0, 9600.0, 38400.0};
    real r;
    r = tst ? t[code] : n[code];
    if (alt) begin
      case (code)
        0:  r = tst ? 7200.0  : 75.0;
        3:  r = tst ? 14400.0 : 150.0;
        7:  r = 2000.0;
        10: r = tst ? 14400.0 : 1800.0;
        12: r = 19200.0;
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic int exp_div(bit tst, bit alt, int code);
    if (code > 12) return 0;
    return $rtoi(REFR / (16.0 * baud(tst, alt, code)) + 0.5);
  endfunction

  // scoreboard monitor: intervals between pulses on source 0
  always @(negedge clk) begin
    if (rst_n && src_ce[0]) begin
      if (have_last && exp_q.size() > 0) begin
        automatic int e = exp_q.pop_front();
        automatic string tg = tag_q.pop_front();
        check(tg, cyc - last_pulse, e);
      end
      last_pulse = cyc;
      have_last  = 1;
      pulse_cnt++;
    end
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    finish_up();
  end

  task automatic bus_op(bit rd, bit wr, logic [3:0] a, bit w);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wbit = w;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic set_all(int code);
    for (int i = 0; i < NSRC; i++) sel_code[i] = 4'(code);
  endtask

  task automatic flush2();
    automatic int n0 = pulse_cnt;
    while (pulse_cnt < n0 + 2) @(negedge clk);
  endtask

  task automatic push_wait(string tg, int e, int n);
    for (int k = 0; k < n; k++) begin exp_q.push_back(e); tag_q.push_back(tg); end
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic table_sweep(string tg, bit alt);
    @(negedge clk);
    rate_set = alt;
    for (int c = 0; c < 16; c++) begin
      set_all(c);
      #1;
      for (int i = 0; i < NSRC; i++)
        check(tg, int'(src_div[i]), exp_div(test_mode, alt, c));
    end
  endtask

  initial begin
    set_all(11);
    repeat (3) @(negedge clk);
    // R1
    check("R1", int'(test_mode), 0);
    check("R1", int'(force_1x), 0);
    check("R1", int'(src_ce), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    table_sweep("R4", 0);
    table_sweep("R5", 1);
    bus_op(1, 0, 4'h2, 0);
    check("R2", int'(test_mode), 1);
    table_sweep("R6", 0);
    table_sweep("R6", 1);
    bus_op(1, 0, 4'h2, 0);
    check("R2", int'(test_mode), 0);

    // R2 no effect from other accesses
    rate_set = 0; set_all(3);
    bus_op(1, 0, 4'h3, 0);
    bus_op(0, 1, 4'h2, 1);
    check("R2", int'(test_mode), 0);
    check("R2", int'(src_div[0]), 1152);

    // R7 every source moves at once
    bus_op(1, 0, 4'h2, 0);
    for (int i = 0; i < NSRC; i++) check("R7", int'(src_div[i]), 12);
    bus_op(1, 0, 4'h2, 0);

    // R8 periods
    set_all(11);
    flush2(); push_wait("R8", 24, 3);
    check("R8", int'(src_1x[0]), 0);
    sel_code[0] = 4'd8;
    flush2(); push_wait("R8", 96, 2);
    bus_op(1, 0, 4'h2, 0);
    sel_code[0] = 4'd6;
    flush2(); push_wait("R8", 2, 3);
    bus_op(1, 0, 4'h2, 0);
    rate_set = 1; sel_code[0] = 4'd0;
    flush2(); push_wait("R8", 3072, 1);
    rate_set = 0;

    // R12 change right after a pulse
    sel_code[0] = 4'd11;
    flush2();
    repeat (3) @(negedge clk);
    sel_code[0] = 4'd9;
    push_wait("R12", 24, 1);
    push_wait("R12", 48, 1);

    // R9 timer bypass on source 1
    sel_code[1] = 4'd13;
    @(negedge clk);
    check("R9", int'(src_div[1]), 0);
    timer_ce = 1;
    @(negedge clk);
    timer_ce = 0;
    check("R9", int'(src_ce[1]), 1);
    @(negedge clk);
    check("R9", int'(src_ce[1]), 0);

    // R10 external enables
    sel_code[2] = 4'd14; sel_code[3] = 4'd15;
    @(negedge clk);
    ext_ce[2] = 1; ext_ce[3] = 1;
    @(negedge clk);
    ext_ce = '0;
    check("R10", int'(src_ce[2]), 1);
    check("R10", int'(src_ce[3]), 1);
    check("R10", int'(src_1x[2]), 0);
    check("R10", int'(src_1x[3]), 1);
    @(negedge clk);
    check("R10", int'(src_ce[2]), 0);

    // R3 and R11 force-1x flag
    bus_op(0, 1, 4'hA, 1);
    check("R3", int'(force_1x), 1);
    check("R11", int'(src_1x), (1 << NSRC) - 1);
    bus_op(1, 0, 4'hA, 0);
    check("R3", int'(force_1x), 1);
    bus_op(0, 1, 4'hA, 0);
    check("R3", int'(force_1x), 0);
    check("R11", int'(src_1x[0]), 0);

    finish_up();
  end

endmodule